// File: doc/BRIEF.md
# Iterative Multiply / Divide / Square-Root Step Unit

This block is the arithmetic step engine of a small stack processor. It holds four 16-bit registers: a top register T, a next register N, a multiplier/divisor register MD and a root register SR. It also holds a one-bit extension E that widens the working remainder to 17 bits. T and N act together as one 32-bit shift pair with T as the high half. On every clock one step command performs a single iteration of a long operation. A surrounding sequencer, or the testbench, issues the same step sixteen times to finish a full multiply, divide or square root. It loads operands through a plain register-write port.

An internal sequence tracker is a small state machine with the states IDLE, MULT, DIVD and ROOT and a step counter. It knows which iteration of a run is executing, and the fractional multiply needs this on its sixteenth step. The transitions are as follows. IDLE to MULT, DIVD or ROOT on the first step of that family. The state holds while steps of the same family continue and the counter is below 15. It returns to IDLE on the sixteenth step, on any register write, on a shift or fixup command, or on a step of another family (that step then starts its own run). A no-operation code holds the state.

Top module: `mdsq_step_unit`

## Requirements
- R1: While reset is low and after its release, T, N, MD, SR and E are all zero.
- R2: With `wr_en` high, `wr_data` is loaded into the register picked by `wr_sel` (0 = T, 1 = N, 2 = MD, 3 = SR) on the next edge, and E is cleared. A step command in the same cycle is ignored.
- R3: Unsigned multiply step (code 1): with T = 0, N = b and MD = a, sixteen steps leave the unsigned product a*b in T:N. MD and SR are unchanged.
- R4: Signed multiply step (code 2): with the same setup, sixteen steps leave the two's-complement product of a and b in T:N.
- R5: Fractional multiply step (code 3): sixteen steps leave the signed product shifted left by one, modulo 2^32, in T:N. This is a Q15 by Q15 product aligned as Q31.
- R6: Divide step (code 4) and fixup step (code 5): with T = 0, N = dividend and MD = nonzero divisor, sixteen divide steps followed by one fixup leave the quotient in N, the remainder in T and E = 0.
- R7: A fixup step while E = 0 leaves T, N and E unchanged.
- R8: Root step (code 6): with MD = 0, SR = 0 and T:N = x, sixteen steps leave floor(sqrt(x)) in SR, x - SR*SR in E:MD, and zero in T and N. Each step moves T:N left by two bits.
- R9: Code 7 shifts T:N right arithmetically by one bit.
- R10: Code 8 shifts T right arithmetically by one bit and leaves N unchanged.
- R11: Code 0 and codes 9 to 15 change no register.
- R12: A register write restarts the step count. A fractional run that is interrupted by a write and then reissued in full gives the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 T, 1 N, 2 MD, 3 SR |
| wr_data | input | 16 | Write value |
| step_op | input | 4 | Step command code |
| t_q | output | 16 | Top register |
| n_q | output | 16 | Next register |
| md_q | output | 16 | Multiplier/divisor/remainder register |
| sr_q | output | 16 | Root register |
| ext_q | output | 1 | Remainder extension bit E |

## Verification
The assertions check the single-cycle relations on every clock. These are register loads and the clearing of E, the two shifts, the stability of all state under no-operation codes, MD and SR staying unchanged under multiply steps, E being clear after a fixup, and the two-bit advance of T:N under root steps. Whether sixteen chained iterations yield the right product, quotient, remainder or root cannot be seen from any single cycle. The bench's reference arithmetic shows this by comparing against a behavioural model once each run has settled, and the same applies to the fractional final shift and to the restart after an interrupted run.

// File: rtl/mdsq_pkg.sv
package mdsq_pkg;

    localparam logic [3:0] OP_NONE  = 4'd0;
    localparam logic [3:0] OP_MULU  = 4'd1;
    localparam logic [3:0] OP_MULS  = 4'd2;
    localparam logic [3:0] OP_MULF  = 4'd3;
    localparam logic [3:0] OP_DIV   = 4'd4;
    localparam logic [3:0] OP_DFIX  = 4'd5;
    localparam logic [3:0] OP_ROOT  = 4'd6;
    localparam logic [3:0] OP_ASR32 = 4'd7;
    localparam logic [3:0] OP_ASR16 = 4'd8;

    localparam logic [1:0] SEL_T  = 2'd0;
    localparam logic [1:0] SEL_N  = 2'd1;
    localparam logic [1:0] SEL_MD = 2'd2;
    localparam logic [1:0] SEL_SR = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MULT,
        ST_DIVD,
        ST_ROOT
    } seq_state_e;

    function automatic seq_state_e op_family(input logic [3:0] op);
        case (op)
            OP_MULU, OP_MULS, OP_MULF: op_family = ST_MULT;
            OP_DIV:                    op_family = ST_DIVD;
            OP_ROOT:                   op_family = ST_ROOT;
            default:                   op_family = ST_IDLE;
        endcase
    endfunction

    function automatic logic op_is_none(input logic [3:0] op);
        op_is_none = (op == OP_NONE) || (op > OP_ASR16);
    endfunction

endpackage

// File: rtl/mdsq_mul_step.sv
module mdsq_mul_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] t_in,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] md_in,
    input  logic         signed_mode,
    input  logic         booth_prev,
    output logic [W-1:0] t_out,
    output logic [W-1:0] n_out
);
    logic [W:0] acc_x;
    logic [W:0] md_x;
    logic [W:0] sum;

    always_comb begin
        if (signed_mode) begin
            acc_x = {t_in[W-1], t_in};
            md_x  = {md_in[W-1], md_in};
            unique case ({n_in[0], booth_prev})
                2'b01:   sum = acc_x + md_x;
                2'b10:   sum = acc_x - md_x;
                default: sum = acc_x;
            endcase
        end else begin
            acc_x = {1'b0, t_in};
            md_x  = {1'b0, md_in};
            sum   = n_in[0] ? (acc_x + md_x) : acc_x;
        end
        t_out = sum[W:1];
        n_out = {sum[0], n_in[W-1:1]};
    end
endmodule

// File: rtl/mdsq_div_step.sv
module mdsq_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] t_in,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] md_in,
    input  logic         ext_in,
    input  logic         fixup,
    output logic [W-1:0] t_out,
    output logic [W-1:0] n_out,
    output logic         ext_out
);
    logic [W+1:0] part;
    logic [W+1:0] dvs;
    logic [W+1:0] res;
    logic [W-1:0] fix_sum;

    always_comb begin
        part    = {ext_in, t_in, n_in[W-1]};
        dvs     = {2'b00, md_in};
        res     = ext_in ? (part + dvs) : (part - dvs);
        fix_sum = t_in + md_in;
        if (fixup) begin
            t_out   = ext_in ? fix_sum : t_in;
            n_out   = n_in;
            ext_out = 1'b0;
        end else begin
            t_out   = res[W-1:0];
            ext_out = res[W];
            n_out   = {n_in[W-2:0], ~res[W+1]};
        end
    end
endmodule

// File: rtl/mdsq_root_step.sv
module mdsq_root_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] t_in,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] md_in,
    input  logic         ext_in,
    input  logic [W-1:0] sr_in,
    output logic [W-1:0] t_out,
    output logic [W-1:0] n_out,
    output logic [W-1:0] md_out,
    output logic         ext_out,
    output logic [W-1:0] sr_out
);
    logic [W+2:0] acc;
    logic [W+2:0] trial;
    logic [W+2:0] diff;
    logic [W+2:0] rem;
    logic         fits;

    always_comb begin
        acc     = {ext_in, md_in, t_in[W-1:W-2]};
        trial   = {1'b0, sr_in, 2'b01};
        diff    = acc - trial;
        fits    = (acc >= trial);
        rem     = fits ? diff : acc;
        md_out  = rem[W-1:0];
        ext_out = rem[W];
        sr_out  = {sr_in[W-2:0], fits};
        t_out   = {t_in[W-3:0], n_in[W-1:W-2]};
        n_out   = {n_in[W-3:0], 2'b00};
    end
endmodule

// File: rtl/mdsq_step_unit.sv
module mdsq_step_unit
    import mdsq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [3:0]   step_op,
    output logic [W-1:0] t_q,
    output logic [W-1:0] n_q,
    output logic [W-1:0] md_q,
    output logic [W-1:0] sr_q,
    output logic         ext_q
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    seq_state_e    state_r, state_nx;
    logic [CW-1:0] cnt_r, cnt_nx;
    logic [CW-1:0] idx;
    logic          last_step;
    seq_state_e    fam;

    logic [W-1:0]  t_r, n_r, md_r, sr_r;
    logic          ext_r, booth_r;
    logic [W-1:0]  t_nx, n_nx, md_nx, sr_nx;
    logic          ext_nx, booth_nx;

    logic [W-1:0]  mul_t, mul_n;
    logic [W-1:0]  div_t, div_n;
    logic          div_e;
    logic [W-1:0]  rt_t, rt_n, rt_md, rt_sr;
    logic          rt_e;
    logic          prev_bit;

    assign fam       = op_family(step_op);
    assign idx       = (state_r == fam && fam != ST_IDLE) ? cnt_r : '0;
    assign last_step = (idx == LAST_IDX);
    assign prev_bit  = (state_r == ST_MULT) ? booth_r : 1'b0;

    mdsq_mul_step #(.W(W)) u_mul (
        .t_in        (t_r),
        .n_in        (n_r),
        .md_in       (md_r),
        .signed_mode (step_op != OP_MULU),
        .booth_prev  (prev_bit),
        .t_out       (mul_t),
        .n_out       (mul_n)
    );

    mdsq_div_step #(.W(W)) u_div (
        .t_in    (t_r),
        .n_in    (n_r),
        .md_in   (md_r),
        .ext_in  (ext_r),
        .fixup   (step_op == OP_DFIX),
        .t_out   (div_t),
        .n_out   (div_n),
        .ext_out (div_e)
    );

    mdsq_root_step #(.W(W)) u_root (
        .t_in    (t_r),
        .n_in    (n_r),
        .md_in   (md_r),
        .ext_in  (ext_r),
        .sr_in   (sr_r),
        .t_out   (rt_t),
        .n_out   (rt_n),
        .md_out  (rt_md),
        .ext_out (rt_e),
        .sr_out  (rt_sr)
    );

    // Sequence tracker: next state
    always_comb begin
        state_nx = state_r;
        cnt_nx   = cnt_r;
        if (wr_en) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else if (op_is_none(step_op)) begin
            state_nx = state_r;
            cnt_nx   = cnt_r;
        end else if (fam == ST_IDLE || last_step) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else begin
            state_nx = fam;
            cnt_nx   = idx + 1'b1;
        end
    end

    // Sequence tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
            cnt_r   <= '0;
        end else begin
            state_r <= state_nx;
            cnt_r   <= cnt_nx;
        end
    end

    // Datapath: next register values
    always_comb begin
        t_nx     = t_r;
        n_nx     = n_r;
        md_nx    = md_r;
        sr_nx    = sr_r;
        ext_nx   = ext_r;
        booth_nx = booth_r;
        if (wr_en) begin
            ext_nx = 1'b0;
            unique case (wr_sel)
                SEL_T:   t_nx  = wr_data;
                SEL_N:   n_nx  = wr_data;
                SEL_MD:  md_nx = wr_data;
                default: sr_nx = wr_data;
            endcase
        end else begin
            unique case (step_op)
                OP_MULU, OP_MULS: begin
                    t_nx     = mul_t;
                    n_nx     = mul_n;
                    booth_nx = n_r[0];
                end
                OP_MULF: begin
                    booth_nx = n_r[0];
                    if (last_step) begin
                        {t_nx, n_nx} = {mul_t, mul_n} << 1;
                    end else begin
                        t_nx = mul_t;
                        n_nx = mul_n;
                    end
                end
                OP_DIV, OP_DFIX: begin
                    t_nx   = div_t;
                    n_nx   = div_n;
                    ext_nx = div_e;
                end
                OP_ROOT: begin
                    t_nx   = rt_t;
                    n_nx   = rt_n;
                    md_nx  = rt_md;
                    ext_nx = rt_e;
                    sr_nx  = rt_sr;
                end
                OP_ASR32: begin
                    {t_nx, n_nx} = {t_r[W-1], t_r, n_r[W-1:1]};
                end
                OP_ASR16: begin
                    t_nx = {t_r[W-1], t_r[W-1:1]};
                end
                default: begin
                    t_nx = t_r;
                end
            endcase
        end
    end

    // Datapath: register bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_r     <= '0;
            n_r     <= '0;
            md_r    <= '0;
            sr_r    <= '0;
            ext_r   <= 1'b0;
            booth_r <= 1'b0;
        end else begin
            t_r     <= t_nx;
            n_r     <= n_nx;
            md_r    <= md_nx;
            sr_r    <= sr_nx;
            ext_r   <= ext_nx;
            booth_r <= booth_nx;
        end
    end

    assign t_q   = t_r;
    assign n_q   = n_r;
    assign md_q  = md_r;
    assign sr_q  = sr_r;
    assign ext_q = ext_r;

endmodule

// File: rtl/mdsq_step_chk.sv
module mdsq_step_chk
    import mdsq_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [3:0]   step_op,
    input logic [W-1:0] t_q,
    input logic [W-1:0] n_q,
    input logic [W-1:0] md_q,
    input logic [W-1:0] sr_q,
    input logic         ext_q
);
    AST_LOAD_T: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_T) |=> (t_q == $past(wr_data))); // R2

    AST_LOAD_CLEARS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ext_q); // R2

    AST_MUL_KEEPS_MD_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_family(step_op) == ST_MULT) |=> ($stable(md_q) && $stable(sr_q))); // R3

    AST_FIX_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_op == OP_DFIX) |=> !ext_q); // R6

    AST_ROOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_op == OP_ROOT) |=> (n_q[1:0] == 2'b00 && t_q[1:0] == $past(n_q[W-1:W-2]))); // R8

    AST_ASR32_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_op == OP_ASR32) |=> ({t_q, n_q} == $past($signed({t_q, n_q}) >>> 1))); // R9

    AST_ASR16_KEEPS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_op == OP_ASR16) |=> ($stable(n_q) && t_q[W-1] == $past(t_q[W-1]))); // R10

    AST_NONE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_is_none(step_op)) |=> ($stable(t_q) && $stable(n_q) && $stable(md_q)
                                             && $stable(sr_q) && $stable(ext_q))); // R11
endmodule

bind mdsq_step_unit mdsq_step_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .step_op (step_op),
    .t_q     (t_q),
    .n_q     (n_q),
    .md_q    (md_q),
    .sr_q    (sr_q),
    .ext_q   (ext_q)
);

// File: tb/mdsq_step_unit_test.sv
`timescale 1ns/1ps
module mdsq_step_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [3:0]  step_op = 4'd0;
    logic [15:0] t_q, n_q, md_q, sr_q;
    logic        ext_q;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    bit    settled  = 1'b1;
    string cur_req  = "R1";

    logic [15:0] m_t = 0, m_n = 0, m_md = 0, m_sr = 0;
    logic        m_x = 0;

    always #2 clk = ~clk;

    mdsq_step_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .step_op(step_op), .t_q(t_q), .n_q(n_q),
        .md_q(md_q), .sr_q(sr_q), .ext_q(ext_q)
    );

    task automatic compare(input string req);
        n_checks++;
        if ({t_q, n_q, md_q, sr_q, ext_q} !== {m_t, m_n, m_md, m_sr, m_x}) begin
            n_fails++;
            $display("FAIL %s: actual T=%h N=%h MD=%h SR=%h E=%b expected T=%h N=%h MD=%h SR=%h E=%b",
                     req, t_q, n_q, md_q, sr_q, ext_q, m_t, m_n, m_md, m_sr, m_x);
        end
    endtask

    // Per-clock comparison against the behavioural model whenever it is settled
    always @(negedge clk) begin
        if (rst_n && settled && !finished) compare(cur_req);
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (s)
            2'd0: m_t = d;
            2'd1: m_n = d;
            2'd2: m_md = d;
            default: m_sr = d;
        endcase
        m_x = 1'b0;
    endtask

    task automatic steps(input logic [3:0] op, input int k);
        settled = 1'b0;
        step_op = op;
        repeat (k) @(posedge clk);
        #1;
        step_op = 4'd0;
    endtask

    task automatic mul_run(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b, input string req);
        int sa, sb;
        logic [31:0] p;
        cur_req = req;
        wr(2'd0, 16'h0); wr(2'd1, b); wr(2'd2, a);
        steps(op, 16);
        sa = $signed(a); sb = $signed(b);
        if (op == 4'd1) p = {16'h0, a} * {16'h0, b};
        else if (op == 4'd2) p = sa * sb;
        else p = (sa * sb) << 1;
        {m_t, m_n} = p;
        settled = 1'b1;
    endtask

    task automatic div_run(input logic [15:0] dd, input logic [15:0] dv);
        cur_req = "R6";
        wr(2'd0, 16'h0); wr(2'd1, dd); wr(2'd2, dv);
        steps(4'd4, 16);
        steps(4'd5, 1);
        m_n = dd / dv; m_t = dd % dv; m_x = 1'b0;
        settled = 1'b1;
    endtask

    task automatic root_run(input logic [31:0] x);
        longint lo, hi, mid, xl;
        logic [16:0] rem;
        cur_req = "R8";
        wr(2'd2, 16'h0); wr(2'd3, 16'h0); wr(2'd0, x[31:16]); wr(2'd1, x[15:0]);
        steps(4'd6, 16);
        xl = longint'(x); lo = 0; hi = 65536;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            if (mid * mid <= xl) lo = mid; else hi = mid;
        end
        rem = 17'(xl - lo * lo);
        m_sr = 16'(lo); {m_x, m_md} = rem; m_t = 0; m_n = 0;
        settled = 1'b1;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); compare("R1");          // R1 during reset
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk); compare("R1");          // R1 after release

        // R2: loads, and write beats a simultaneous step
        cur_req = "R2";
        wr(2'd3, 16'hA5A5); wr(2'd2, 16'h0F0F); wr(2'd0, 16'h8001);
        step_op = 4'd8; wr(2'd1, 16'h1234); step_op = 4'd0;
        @(negedge clk); compare("R2");

        // R10 / R9 shifts
        cur_req = "R10";
        steps(4'd8, 1); m_t = 16'hC000; settled = 1'b1;
        @(negedge clk); compare("R10");
        cur_req = "R9";
        wr(2'd0, 16'h8001); wr(2'd1, 16'h0003);
        steps(4'd7, 1); m_t = 16'hC000; m_n = 16'h8001; settled = 1'b1;
        @(negedge clk); compare("R9");

        // R11 no-operation codes
        cur_req = "R11";
        steps(4'd0, 2); settled = 1'b1;
        steps(4'd9, 1); settled = 1'b1;
        steps(4'd15, 3); settled = 1'b1;
        @(negedge clk); compare("R11");

        // R3 unsigned multiply
        mul_run(4'd1, 16'hFFFF, 16'hFFFF, "R3");
        mul_run(4'd1, 16'h1234, 16'h00AB, "R3");
        mul_run(4'd1, 16'h0000, 16'h5555, "R3");
        // R4 signed multiply
        mul_run(4'd2, 16'h8000, 16'h8000, "R4");
        mul_run(4'd2, 16'hFFFF, 16'h0003, "R4");
        mul_run(4'd2, 16'h7FFF, 16'h8000, "R4");
        mul_run(4'd2, 16'h1234, 16'hFEDC, "R4");
        // R5 fractional multiply
        mul_run(4'd3, 16'h4000, 16'h4000, "R5");
        mul_run(4'd3, 16'h8000, 16'h8000, "R5");
        mul_run(4'd3, 16'hC000, 16'h2000, "R5");
        @(negedge clk); compare("R5");

        // R12 interrupted fractional run restarts after a write
        cur_req = "R12";
        wr(2'd0, 16'h0); wr(2'd1, 16'h3000); wr(2'd2, 16'h5000);
        steps(4'd3, 5);
        mul_run(4'd3, 16'hE000, 16'h6000, "R12");
        @(negedge clk); compare("R12");

        // R6 divide
        div_run(16'hFFFF, 16'h0001);
        div_run(16'd1000, 16'd7);
        div_run(16'h1234, 16'hFFFF);
        div_run(16'd5, 16'd9);
        div_run(16'hFFFF, 16'h8001);
        @(negedge clk); compare("R6");

        // R7 fixup with E clear changes nothing
        cur_req = "R7";
        wr(2'd0, 16'h4321); wr(2'd1, 16'h8765);
        steps(4'd5, 1); settled = 1'b1;
        @(negedge clk); compare("R7");

        // R8 square root
        root_run(32'hFFFFFFFF);
        root_run(32'd0);
        root_run(32'd1000000);
        root_run(32'd2);
        root_run(32'h40000000);
        @(negedge clk); compare("R8");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule